// File: doc/BRIEF.md
# Sliding 3x3 Window Line Buffer

This block turns a raster-order stream of 8-bit pixels into a 3x3 neighbourhood suitable for a streaming image kernel. One pixel can be accepted on every clock. Instead of holding a whole frame, it keeps only the two image rows that came before the current one, each in its own single-write, single-read row memory that is `WIDTH` entries deep. The third row of the neighbourhood comes straight from the live input.

A column pointer addresses both row memories and wraps at the end of each image line. A shift reads both memories at the current column and writes the new pixel into the younger memory in the same cycle. Because the memory reads are synchronous, a two-state commit phase machine moves the window one cycle later. It has two states. `PH_IDLE` means nothing is pending. `PH_COMMIT` means the read data of the previous shift is waiting to enter the window.

The transitions are:
- `PH_IDLE` to `PH_COMMIT` on a shift.
- `PH_COMMIT` to `PH_COMMIT` on a back-to-back shift.
- `PH_COMMIT` to `PH_IDLE` on a cycle without a shift.
- Reset forces `PH_IDLE`.

In the commit cycle the older memory takes the value that was read from the younger one, and every window row moves left by one column. The window is indexed `[row][col]`. Row 2 is the live row, and rows 1 and 0 are one and two lines older. Column 2 is the newest column, and column 0 is the oldest. `WIDTH` must be at least 2.

Top module: `sliding_window_lb`

## Requirements
- R1: A synchronous reset clears all nine window entries to zero. Window row 2 keeps zeros in every position that no pixel has reached since the reset.
- R2: Reset returns the column pointer to 0, so the first pixel after reset is treated as column 0 of a new line. The content of the row memories is not cleared.
- R3: A pixel shifted on clock edge k appears in `win_o[2][2]` after edge k+1. `win_o[2][1]` and `win_o[2][0]` hold the one and two pixels before it.
- R4: `win_o[1][c]` holds the pixel that was shifted exactly `WIDTH` shifts before the one in `win_o[2][c]`.
- R5: `win_o[0][c]` holds the pixel that was shifted exactly `2*WIDTH` shifts before the one in `win_o[2][c]`.
- R6: A cycle without `shift_en` leaves the window unchanged once pending data has committed. It also does not advance the stream position.
- R7: The column pointer stays below `WIDTH` and wraps from `WIDTH-1` to 0. Row alignment therefore holds across line boundaries without any gap in the stream.
- R8: On each commit, every window row moves left by one column and takes the new column at index 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | Accepts `pix_i` into the stream this cycle |
| pix_i | input | PIX_W | Incoming pixel, raster order |
| win_o | output | 3x3xPIX_W | Neighbourhood window, `[row][col]`, row 2 and column 2 newest |

## Verification
The assertions assume two things. First, `shift_en` is held low while reset is high. Second, the first `2*WIDTH` shifts after a reset may expose undefined memory data in rows 0 and 1. For that reason, the property on the newest entry and the hold property refer only to row 2 and to the commit phase. The stimulus keeps `shift_en` low during every reset. It mixes random strobe densities with long back-to-back bursts and idle gaps. Reference comparisons of rows 0 and 1 are skipped wherever the source pixel predates the last reset. A mid-line reset is included so that the pointer is not at zero when it is cleared.

// File: rtl/lb_pkg.sv
package lb_pkg;
    localparam int WIN_N = 3;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_COMMIT = 1'b1
    } phase_e;
endpackage

// File: rtl/lb_row_store.sv
module lb_row_store #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata
);
    logic [DW-1:0] mem [DEPTH];

    // Read-first: a read and a write to one address in one cycle return the old word.
    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[raddr];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end
endmodule

// File: rtl/lb_col_ptr.sv
module lb_col_ptr #(
    parameter int WIDTH = 512,
    localparam int CW   = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [CW-1:0] col_o
);
    localparam logic [CW-1:0] LAST = CW'(WIDTH - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            col_o <= '0;
        end else if (adv) begin
            col_o <= (col_o == LAST) ? '0 : col_o + 1'b1;
        end
    end

    a_r7_ptr_range : assert property (@(posedge clk) disable iff (rst)
        int'(col_o) < WIDTH);

    a_r7_ptr_wrap : assert property (@(posedge clk) disable iff (rst)
        (adv && col_o == LAST) |=> (col_o == '0));

    a_r2_ptr_reset : assert property (@(posedge clk)
        rst |=> (col_o == '0));
endmodule

// File: rtl/lb_window.sv
module lb_window #(
    parameter int PIX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          ld,
    input  logic [PIX_W-1:0]              old_px,
    input  logic [PIX_W-1:0]              mid_px,
    input  logic [PIX_W-1:0]              new_px,
    output logic [2:0][2:0][PIX_W-1:0]    win_o
);
    logic [2:0][PIX_W-1:0] col_in;

    assign col_in[0] = old_px;
    assign col_in[1] = mid_px;
    assign col_in[2] = new_px;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_o <= '0;
        end else if (ld) begin
            for (int r = 0; r < lb_pkg::WIN_N; r++) begin
                win_o[r][0] <= win_o[r][1];
                win_o[r][1] <= win_o[r][2];
                win_o[r][2] <= col_in[r];
            end
        end
    end

    a_r6_hold : assert property (@(posedge clk) disable iff (rst)
        !ld |=> $stable(win_o));

    a_r8_shift_left : assert property (@(posedge clk) disable iff (rst)
        ld |=> (win_o[1][0] == $past(win_o[1][1]) && win_o[0][1] == $past(win_o[0][2])));

    a_r1_clear : assert property (@(posedge clk)
        rst |=> (win_o == '0));
endmodule

// File: rtl/sliding_window_lb.sv
module sliding_window_lb #(
    parameter int WIDTH = 512,
    parameter int PIX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [PIX_W-1:0]           pix_i,
    output logic [2:0][2:0][PIX_W-1:0] win_o
);
    import lb_pkg::*;

    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    phase_e           ph_q;
    phase_e           ph_d;
    logic             commit;
    logic [CW-1:0]    col;
    logic [CW-1:0]    col_q;
    logic [PIX_W-1:0] pix_q;
    logic [PIX_W-1:0] rd_young;
    logic [PIX_W-1:0] rd_old;

    // Commit phase state register
    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q <= PH_IDLE;
        end else begin
            ph_q <= ph_d;
        end
    end

    // Next-phase logic
    always_comb begin
        ph_d = PH_IDLE;
        unique case (ph_q)
            PH_IDLE:   ph_d = shift_en ? PH_COMMIT : PH_IDLE;
            PH_COMMIT: ph_d = shift_en ? PH_COMMIT : PH_IDLE;
            default:   ph_d = PH_IDLE;
        endcase
    end

    // Phase outputs
    always_comb begin
        commit = 1'b0;
        unique case (ph_q)
            PH_IDLE:   commit = 1'b0;
            PH_COMMIT: commit = 1'b1;
            default:   commit = 1'b0;
        endcase
    end

    // Stage that travels alongside the synchronous memory read
    always_ff @(posedge clk) begin
        if (shift_en) begin
            pix_q <= pix_i;
            col_q <= col;
        end
    end

    lb_col_ptr #(.WIDTH(WIDTH)) u_col (
        .clk   (clk),
        .rst   (rst),
        .adv   (shift_en),
        .col_o (col)
    );

    // Younger row store: last line, written with the live pixel
    lb_row_store #(.DEPTH(WIDTH), .DW(PIX_W)) u_row_young (
        .clk   (clk),
        .re    (shift_en),
        .raddr (col),
        .rdata (rd_young),
        .we    (shift_en && !rst),
        .waddr (col),
        .wdata (pix_i)
    );

    // Older row store: two lines back, written one cycle later with the word
    // just read from the younger store
    lb_row_store #(.DEPTH(WIDTH), .DW(PIX_W)) u_row_old (
        .clk   (clk),
        .re    (shift_en),
        .raddr (col),
        .rdata (rd_old),
        .we    (commit),
        .waddr (col_q),
        .wdata (rd_young)
    );

    lb_window #(.PIX_W(PIX_W)) u_win (
        .clk    (clk),
        .rst    (rst),
        .ld     (commit),
        .old_px (rd_old),
        .mid_px (rd_young),
        .new_px (pix_q),
        .win_o  (win_o)
    );

    a_r3_newest : assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ##1 (win_o[2][2] == $past(pix_i, 2)));

    a_r4_mid_entry : assert property (@(posedge clk) disable iff (rst)
        commit |=> (win_o[1][2] == $past(rd_young)));

    a_r6_phase_idle : assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (ph_q == PH_IDLE));
endmodule

// File: tb/sliding_window_lb_tb.sv
`timescale 1ns/1ps
module sliding_window_lb_tb;
    localparam int W     = 12;
    localparam int PIX_W = 8;
    localparam int HMAX  = 8192;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       shift_en = 1'b0;
    logic [PIX_W-1:0]           pix_i = '0;
    logic [2:0][2:0][PIX_W-1:0] win_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [PIX_W-1:0]           hist [HMAX];
    int                         n_s = 0;
    int                         n_c = 0;
    int                         n_c_prev = -1;
    logic [2:0][2:0][PIX_W-1:0] prev_win;

    sliding_window_lb #(.WIDTH(W), .PIX_W(PIX_W)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .pix_i    (pix_i),
        .win_o    (win_o)
    );

    always #2 clk = ~clk;

    function automatic int src_index(int n, int r, int c);
        return n - 1 - (2 - c) - (2 - r) * W;
    endfunction

    function automatic string row_tag(int r);
        if (r == 2) return "R3";
        if (r == 1) return "R4";
        return "R5";
    endfunction

    task automatic check_window();
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                int idx;
                idx = src_index(n_c, r, c);
                if (idx >= 0) begin
                    checks++;
                    if (win_o[r][c] !== hist[idx]) begin
                        failures++;
                        $display("FAIL %s win[%0d][%0d] actual=%0h expected=%0h",
                                 row_tag(r), r, c, win_o[r][c], hist[idx]);
                    end
                end else if (r == 2) begin
                    checks++; // R1: untouched live-row slots stay zero
                    if (win_o[r][c] !== '0) begin
                        failures++;
                        $display("FAIL R1 win[2][%0d] actual=%0h expected=0", c, win_o[r][c]);
                    end
                end
            end
        end
        if (n_c == n_c_prev) begin
            checks++; // R6: no commit -> window held
            if (win_o !== prev_win) begin
                failures++;
                $display("FAIL R6 hold actual=%0h expected=%0h", win_o, prev_win);
            end
        end
        prev_win = win_o;
        n_c_prev = n_c;
    endtask

    task automatic step(bit en, logic [PIX_W-1:0] px);
        @(negedge clk);
        check_window();
        n_c = n_s;
        shift_en = en;
        pix_i    = px;
        if (en) begin
            hist[n_s] = px;
            n_s++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        shift_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        checks++; // R1
        if (win_o !== '0) begin
            failures++;
            $display("FAIL R1 reset window actual=%0h expected=0", win_o);
        end
        rst = 1'b0;
        n_s = 0;
        n_c = 0;
        n_c_prev = -1;
    endtask

    task automatic random_run(int cycles, int pct);
        for (int i = 0; i < cycles; i++) begin
            step(($urandom % 100) < pct, PIX_W'($urandom));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // Directed: extreme values in a continuous burst over several lines (R7 wrap)
        for (int i = 0; i < 4 * W; i++) begin
            step(1'b1, (i % 2 == 0) ? 8'hFF : 8'h00);
        end
        // Long idle gap (R6)
        for (int i = 0; i < 6; i++) step(1'b0, 8'hA5);
        // Random density mixes
        random_run(400, 70);
        random_run(200, 20);
        // Burst with a recognisable ramp across line boundaries (R4, R5, R7)
        for (int i = 0; i < 3 * W + 5; i++) step(1'b1, PIX_W'(i + 1));
        // Mid-line reset: pointer non-zero before reset (R2)
        for (int i = 0; i < 5; i++) step(1'b1, PIX_W'(8'h40 + i));
        step(1'b0, 8'h00);
        do_reset();
        for (int i = 0; i < 3 * W; i++) step(1'b1, PIX_W'(8'h80 + i)); // R2 alignment
        random_run(600, 85);
        for (int i = 0; i < 4; i++) step(1'b0, 8'h00);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule